// File: doc/BRIEF.md
# Multi-row reservation station

This block wraps a single shared processing unit with a valid/ready handshake. It presents that unit to the outside as `NROWS` identical units. Each row has its own input port and its own output port, so an issue scheduler can track hazards per row as if each row were a separate unit. Only one datapath exists behind the rows. Each row holds at most one operation at a time. The operation carries its operands and a set of per-field "data ok" flags.

When the shared unit can take an operation in the cycle a row receives it, the operands pass straight through to the unit that cycle. When the unit's result appears in a cycle where the owning row's consumer is ready, the result leaves on that row's output in the same cycle. The rows therefore add no cycles to the unit's own latency.

The block falls back to registered buffering in two cases. The first is when the unit is busy or another row wins the unit. The second is when a consumer stalls. Requests carry the row index as a tag, and the unit returns the tag with the result. A round-robin arbiter decides among competing rows. For test, the unit adds the two operands with `LAT` pipeline stages and accepts a new request only every `GAP+1` cycles.

Top module: `rs_station`

## Requirements
- R1: The row count `NROWS` is a parameter, and a build with `NROWS = 1` accepts, computes and delivers operations like any other build.
- R2: An idle row whose input is valid, that is granted the unit and finds the unit ready, hands its operands to the unit in that same cycle. Its result appears on the row output exactly `LAT` cycles after the input handshake.
- R3: When the result returns and the row's `out_ready` is high in that cycle, `out_valid` rises in that cycle with the result on `out_data`, and no extra register stage is added.
- R4: If `out_ready` is low when the result returns, the row buffers the result. It keeps `out_valid` high and `out_data` stable until `out_ready` is high, and clears `out_valid` in the cycle after that handshake.
- R5: A row's `in_ready` is high exactly when the row holds no undelivered operand or result. An operand that loses arbitration, or meets a busy unit, is held in the row until it is sent.
- R6: Rows requesting in the same cycle are served in round-robin order. The order starts at the row after the last granted row, and at row 0 after reset.
- R7: `out_wmask` of a row is a register holding the OR of the ok flags of the last result delivered on that row. It changes only in the cycle after an output handshake. Ok flags on the input are taken only with an input handshake, and changes to them at any other time have no effect.
- R8: After a synchronous reset (`rst` high at a clock edge), every `in_ready` is high and every `out_valid` and `out_wmask` bit is low.
- R9: Each result is returned only on the row that issued it, and its value is `in_a + in_b` modulo 2^16.
- R10: The shared unit accepts at most one request every `GAP+1` cycles, so the results of requests queued together leave `GAP+1` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NROWS | Per-row operand valid |
| in_ready | output | NROWS | Per-row operand ready (row empty) |
| in_a | input | NROWS x 16 | Per-row first operand |
| in_b | input | NROWS x 16 | Per-row second operand |
| in_ok | input | NROWS x 2 | Per-row "data ok" flags for the result fields |
| out_valid | output | NROWS | Per-row result valid |
| out_ready | input | NROWS | Per-row consumer ready |
| out_data | output | NROWS x 16 | Per-row result value |
| out_wmask | output | NROWS | Per-row registered write mask (OR of delivered ok flags) |

## Verification
The main bench builds the block with three rows, a two-stage unit and a one-cycle gap between accepts. This mix makes arbitration losses, held operands and the unit's not-ready cycles occur alongside random consumer stalls, and it gives a rotating arbiter pointer that lands on a non-power-of-two wrap. A second instance uses one row, a one-stage unit and no gap. This covers the degenerate arbiter and the tightest return path, where the result appears in the cycle after acceptance.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int unsigned DW   = 16;  // operand / result width
    parameter int unsigned OKW  = 2;   // number of result fields with a data-ok flag
    parameter int unsigned TAGW = 4;   // row tag width, allows up to 16 rows

    typedef struct packed {
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        logic [OKW-1:0] ok;
    } rs_op_t;

    typedef struct packed {
        logic [DW-1:0]  val;
        logic [OKW-1:0] ok;
    } rs_res_t;

    typedef struct packed {
        rs_op_t          op;
        logic [TAGW-1:0] tag;
    } rs_req_t;

    typedef struct packed {
        rs_res_t         res;
        logic [TAGW-1:0] tag;
    } rs_rsp_t;

    typedef enum logic [1:0] {
        ROW_IDLE,
        ROW_HOLD_IN,
        ROW_BUSY,
        ROW_HOLD_OUT
    } row_state_e;

    function automatic rs_res_t unit_compute(rs_op_t op);
        rs_res_t r;
        r.val = op.a + op.b;
        r.ok  = op.ok;
        return r;
    endfunction
endpackage

// File: rtl/rs_rr_arbiter.sv
module rs_rr_arbiter #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         accept,
    output logic [N-1:0] grant
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] gidx;
    logic          found;

    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            int idx;
            idx = (int'(ptr) + k) % int'(N);
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (accept && found) begin
            ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + IW'(1);
        end
    end

    assert_onehot_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));
    assert_no_idle_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (grant != '0));
endmodule

// File: rtl/rs_pipe_unit.sv
module rs_pipe_unit import rs_pkg::*; #(
    parameter int unsigned LAT = 3,
    parameter int unsigned GAP = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    output logic    in_ready,
    input  rs_req_t in_req,
    output logic    out_valid,
    input  logic    out_ready,
    output rs_rsp_t out_rsp
);
    localparam int unsigned GW = $clog2(GAP + 2);

    rs_rsp_t       stg [LAT];
    logic [LAT-1:0] vld;
    logic [GW-1:0] gap_cnt;
    logic          advance;
    logic          fire;

    assign advance  = !vld[LAT-1] || out_ready;
    assign in_ready = advance && (gap_cnt == '0);
    assign fire     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= '0;
            gap_cnt <= '0;
        end else begin
            if (fire)               gap_cnt <= GW'(GAP);
            else if (gap_cnt != '0) gap_cnt <= gap_cnt - GW'(1);
            if (advance) begin
                vld[0] <= fire;
                for (int i = 1; i < int'(LAT); i++) vld[i] <= vld[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (advance) begin
            stg[0].res <= unit_compute(in_req.op);
            stg[0].tag <= in_req.tag;
            for (int i = 1; i < int'(LAT); i++) stg[i] <= stg[i-1];
        end
    end

    assign out_valid = vld[LAT-1];
    assign out_rsp   = stg[LAT-1];

    assert_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (GAP > 0) && in_valid && in_ready |=> !in_ready);
endmodule

// File: rtl/rs_row.sv
module rs_row import rs_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  rs_op_t        in_op,
    output logic          req,
    output rs_op_t        req_op,
    input  logic          grant,
    input  logic          unit_ready,
    input  logic          rsp_valid,
    input  rs_res_t       rsp_res,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_wmask,
    output logic          busy
);
    row_state_e state;
    rs_op_t     op_q;
    rs_res_t    res_q;
    rs_res_t    out_res;
    logic       send;

    assign in_ready  = (state == ROW_IDLE);
    assign req       = (in_ready && in_valid) || (state == ROW_HOLD_IN);
    assign req_op    = (state == ROW_HOLD_IN) ? op_q : in_op;
    assign send      = req && grant && unit_ready;
    assign busy      = (state == ROW_BUSY);
    assign out_valid = (state == ROW_HOLD_OUT) || (busy && rsp_valid);
    assign out_res   = (state == ROW_HOLD_OUT) ? res_q : rsp_res;
    assign out_data  = out_res.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ROW_IDLE;
            out_wmask <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_wmask <= |out_res.ok;
            unique case (state)
                ROW_IDLE:     if (in_valid) state <= send ? ROW_BUSY : ROW_HOLD_IN;
                ROW_HOLD_IN:  if (send) state <= ROW_BUSY;
                ROW_BUSY:     if (rsp_valid) state <= out_ready ? ROW_IDLE : ROW_HOLD_OUT;
                ROW_HOLD_OUT: if (out_ready) state <= ROW_IDLE;
                default:      state <= ROW_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid)       op_q  <= in_op;
        if (busy && rsp_valid && !out_ready) res_q <= rsp_res;
    end

    assert_one_inflight_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);
    assert_hold_result_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    assert_wmask_only_on_handshake_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(out_wmask));
endmodule

// File: rtl/rs_station.sv
module rs_station import rs_pkg::*; #(
    parameter int unsigned NROWS = 4,   // at most 2**TAGW
    parameter int unsigned LAT   = 3,   // unit pipeline depth, at least 1
    parameter int unsigned GAP   = 0    // unit idle cycles after each accept
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NROWS-1:0]           in_valid,
    output logic [NROWS-1:0]           in_ready,
    input  logic [NROWS-1:0][DW-1:0]   in_a,
    input  logic [NROWS-1:0][DW-1:0]   in_b,
    input  logic [NROWS-1:0][OKW-1:0]  in_ok,
    output logic [NROWS-1:0]           out_valid,
    input  logic [NROWS-1:0]           out_ready,
    output logic [NROWS-1:0][DW-1:0]   out_data,
    output logic [NROWS-1:0]           out_wmask
);
    logic [NROWS-1:0] row_req;
    logic [NROWS-1:0] row_grant;
    logic [NROWS-1:0] row_busy;
    logic [NROWS-1:0] rsp_hit;
    rs_op_t           row_op [NROWS];
    rs_req_t          u_req;
    rs_rsp_t          u_rsp;
    logic             u_in_ready;
    logic             u_out_valid;

    rs_rr_arbiter #(.N(NROWS)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (row_req),
        .accept (u_in_ready),
        .grant  (row_grant)
    );

    always_comb begin
        u_req = '0;
        for (int r = 0; r < int'(NROWS); r++) begin
            if (row_grant[r]) begin
                u_req.op  = row_op[r];
                u_req.tag = TAGW'(r);
            end
        end
    end

    // Each row has room for its own result, so the unit is never back-pressured.
    rs_pipe_unit #(.LAT(LAT), .GAP(GAP)) u_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (|row_grant),
        .in_ready  (u_in_ready),
        .in_req    (u_req),
        .out_valid (u_out_valid),
        .out_ready (1'b1),
        .out_rsp   (u_rsp)
    );

    for (genvar r = 0; r < int'(NROWS); r++) begin : g_row
        rs_op_t op_in;
        assign op_in   = '{a: in_a[r], b: in_b[r], ok: in_ok[r]};
        assign rsp_hit[r] = u_out_valid && (u_rsp.tag == TAGW'(r));

        rs_row u_row (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid[r]),
            .in_ready   (in_ready[r]),
            .in_op      (op_in),
            .req        (row_req[r]),
            .req_op     (row_op[r]),
            .grant      (row_grant[r]),
            .unit_ready (u_in_ready),
            .rsp_valid  (rsp_hit[r]),
            .rsp_res    (u_rsp.res),
            .out_valid  (out_valid[r]),
            .out_ready  (out_ready[r]),
            .out_data   (out_data[r]),
            .out_wmask  (out_wmask[r]),
            .busy       (row_busy[r])
        );
    end

    assert_route_to_busy_row_R9: assert property (@(posedge clk) disable iff (rst)
        u_out_valid |-> $onehot(rsp_hit & row_busy));
    assert_out_only_when_owned_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid & in_ready) == '0);
endmodule

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;
    import rs_pkg::*;
    localparam int N = 3, LAT = 2, GAP = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [N-1:0]          in_valid = '0, in_ready, out_valid, out_ready = '0, out_wmask;
    logic [N-1:0][DW-1:0]  in_a = '0, in_b = '0, out_data;
    logic [N-1:0][OKW-1:0] in_ok = '0;

    logic [0:0]          s_in_valid = '0, s_in_ready, s_out_valid, s_out_ready = '0, s_out_wmask;
    logic [0:0][DW-1:0]  s_in_a = '0, s_in_b = '0, s_out_data;
    logic [0:0][OKW-1:0] s_in_ok = '0;

    rs_station #(.NROWS(N), .LAT(LAT), .GAP(GAP)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_ok(in_ok), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_wmask(out_wmask));

    rs_station #(.NROWS(1), .LAT(1), .GAP(0)) dut_single (
        .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_ready(s_in_ready),
        .in_a(s_in_a), .in_b(s_in_b), .in_ok(s_in_ok), .out_valid(s_out_valid),
        .out_ready(s_out_ready), .out_data(s_out_data), .out_wmask(s_out_wmask));

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard model of the requirements, evaluated between edges
    bit            pend [N];
    logic [DW-1:0] pval [N];
    bit            pwm  [N];
    bit            last_wm [N];
    bit            acc  [N];
    int            order_q [$];
    int            time_q  [$];

    function automatic logic [DW-1:0] exp_sum(logic [DW-1:0] a, logic [DW-1:0] b);
        return a + b;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int r = 0; r < N; r++) begin
                pend[r] = 0; last_wm[r] = 0; acc[r] = 0;
            end
        end else begin
            for (int r = 0; r < N; r++) begin
                check_eq("R7", $sformatf("row%0d wmask held", r), out_wmask[r], last_wm[r]);
                check_eq("R5", $sformatf("row%0d in_ready vs occupancy", r), in_ready[r], !pend[r]);
                acc[r] = 0;
                if (out_valid[r]) begin
                    if (!pend[r]) check_eq("R9", $sformatf("row%0d spurious out_valid", r), 1, 0);
                    else check_eq("R9", $sformatf("row%0d data", r), out_data[r], pval[r]);
                    if (out_ready[r]) begin
                        pend[r] = 0;
                        last_wm[r] = pwm[r];
                        order_q.push_back(r);
                        time_q.push_back(cyc);
                    end
                end
                if (in_valid[r] && in_ready[r]) begin
                    pend[r] = 1;
                    pval[r] = exp_sum(in_a[r], in_b[r]);
                    pwm[r]  = |in_ok[r];
                    acc[r]  = 1;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        s_in_valid = '0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic drive_row(int r, int a, int b, int ok);
        in_valid[r] = 1'b1;
        in_a[r] = DW'(a);
        in_b[r] = DW'(b);
        in_ok[r] = OKW'(ok);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20211107));
        do_reset();

        // R8: reset state
        @(negedge clk);
        check_eq("R8", "in_ready after reset", in_ready, 3'b111);
        check_eq("R8", "out_valid after reset", out_valid, 0);
        check_eq("R8", "wmask after reset", out_wmask, 0);
        check_eq("R8", "single-row in_ready after reset", s_in_ready, 1);

        // R2 / R3: zero added latency on both paths
        tick();
        out_ready = '1;
        drive_row(0, 100, 23, 1);
        @(negedge clk);
        check_eq("R2", "accepted same cycle", in_ready[0], 1);
        tick();
        in_valid = '0;
        @(negedge clk);
        check_eq("R2", "no result after 1 cycle", out_valid[0], 0);
        tick();
        @(negedge clk);
        check_eq("R3", "result after LAT cycles", out_valid[0], 1);
        check_eq("R3", "result data", out_data[0], 123);
        tick();
        @(negedge clk);
        check_eq("R3", "valid cleared after delivery", out_valid[0], 0);
        check_eq("R7", "wmask from ok=01", out_wmask[0], 1);

        // R4: consumer stall buffers the result
        tick();
        out_ready[0] = 1'b0;
        drive_row(0, 7, 8, 0);
        tick();
        in_valid = '0;
        tick();
        @(negedge clk);
        check_eq("R4", "stalled result visible", out_valid[0], 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            @(negedge clk);
            check_eq("R4", "valid held", out_valid[0], 1);
            check_eq("R4", "data held", out_data[0], 15);
            check_eq("R7", "wmask unchanged during stall", out_wmask[0], 1);
        end
        tick();
        out_ready[0] = 1'b1;
        @(negedge clk);
        check_eq("R4", "valid at release", out_valid[0], 1);
        tick();
        @(negedge clk);
        check_eq("R4", "valid cleared after handshake", out_valid[0], 0);
        check_eq("R7", "wmask from ok=00", out_wmask[0], 0);

        // R7: ok flags without a handshake are ignored
        for (int k = 0; k < 4; k++) begin
            tick();
            in_ok = '1;
            in_a = '1;
            @(negedge clk);
            check_eq("R7", "wmask idle with garbage flags", out_wmask, 0);
        end
        tick();
        drive_row(1, 3, 4, 0);
        tick();
        in_valid = '0;
        in_ok = '1;
        repeat (4) tick();
        @(negedge clk);
        check_eq("R7", "row1 wmask uses handshake flags", out_wmask[1], 0);

        // R6 / R10 / R5: round robin from reset, then rotated
        do_reset();
        out_ready = '1;
        order_q.delete();
        time_q.delete();
        tick();
        drive_row(0, 1, 1, 1);
        drive_row(1, 2, 2, 2);
        drive_row(2, 3, 3, 3);
        tick();
        in_valid = '0;
        @(negedge clk);
        check_eq("R5", "row2 still held", in_ready[2], 0);
        repeat (10) tick();
        check_eq("R6", "deliveries in round 1", order_q.size(), 3);
        if (order_q.size() == 3) begin
            check_eq("R6", "first grant", order_q[0], 0);
            check_eq("R6", "second grant", order_q[1], 1);
            check_eq("R6", "third grant", order_q[2], 2);
            check_eq("R10", "spacing 0-1", time_q[1] - time_q[0], GAP + 1);
            check_eq("R10", "spacing 1-2", time_q[2] - time_q[1], GAP + 1);
        end
        drive_row(1, 9, 9, 0);
        tick();
        in_valid = '0;
        repeat (6) tick();
        order_q.delete();
        drive_row(0, 10, 1, 0);
        drive_row(1, 20, 2, 0);
        drive_row(2, 30, 3, 0);
        tick();
        in_valid = '0;
        repeat (10) tick();
        check_eq("R6", "deliveries in round 2", order_q.size(), 3);
        if (order_q.size() == 3) begin
            check_eq("R6", "rotated first", order_q[0], 2);
            check_eq("R6", "rotated second", order_q[1], 0);
            check_eq("R6", "rotated third", order_q[2], 1);
        end

        // R1: single-row build
        tick();
        s_out_ready = 1'b1;
        s_in_valid = 1'b1; s_in_a[0] = 16'd5; s_in_b[0] = 16'd6; s_in_ok[0] = 2'b10;
        @(negedge clk);
        check_eq("R1", "single row accepts", s_in_ready, 1);
        tick();
        s_in_valid = 1'b0;
        @(negedge clk);
        check_eq("R1", "single row result valid", s_out_valid, 1);
        check_eq("R1", "single row data", s_out_data[0], 11);
        check_eq("R1", "single row busy", s_in_ready, 0);
        tick();
        @(negedge clk);
        check_eq("R1", "single row delivered", s_out_valid, 0);
        check_eq("R1", "single row wmask", s_out_wmask, 1);
        check_eq("R1", "single row free again", s_in_ready, 1);

        // Random traffic with consumer stalls; scoreboard checks R5 R7 R9
        for (int c = 0; c < 3000; c++) begin
            tick();
            for (int r = 0; r < N; r++) begin
                if (!in_valid[r] || acc[r]) begin
                    in_valid[r] = ($urandom % 2) == 1;
                    in_a[r]  = DW'($urandom);
                    in_b[r]  = DW'($urandom);
                    in_ok[r] = OKW'($urandom);
                end
                out_ready[r] = ($urandom % 4) != 0;
            end
        end
        tick();
        in_valid = '0;
        out_ready = '1;
        repeat (20) tick();
        @(negedge clk);
        for (int r = 0; r < N; r++)
            check_eq("R9", $sformatf("row%0d drained", r), pend[r], 0);

        summary();
        $finish;
    end
endmodule